// File: doc/BRIEF.md
# Configurable Noise Shift-Register Generator

This block is the noise voice of a square-wave sound generator. A countdown timer runs on a divided clock strobe. Each time the countdown expires, a right-shifting linear feedback register advances once. The lowest bit of that register is the noise level that goes on to the mixer.

A mode input selects between two outputs from the same datapath:
- White noise, where two tap bits feed back through an XOR.
- Periodic noise, where the second tap is forced to its neutral value. The register then recirculates a single ring pattern.

Parameters choose the register length, the two tap masks and the feedback polarity (XOR or XNOR), so the block can be set up for different chip variants. A clear pulse reloads the register with only its top bit set.

Choosing the period and weighting the level are done outside the block.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst` is high, the shift register is set to its top bit only (bit 16 with the defaults), `noise_out` is 0, and the countdown is 0. The first `tick` after reset therefore causes a step.
- R2: On a cycle with `tick` high, the countdown is checked. If it is at 1 or below, a step occurs and the countdown reloads with `period`. Otherwise the countdown decreases by 1. Without `tick`, neither the countdown nor the register changes. With a constant `period` of N≥1, steps come every N ticks.
- R3: A `period` of 0 behaves like 1: a step occurs on every tick.
- R4: A step shifts the register right by one place. The top bit (the feedback mask bit) becomes the feedback value.
- R5: In white mode (`white_mode`=1) with XOR polarity, the feedback is the tap A bit XOR the tap B bit. With the defaults, tap A is bit 2 and tap B is bit 3.
- R6: In periodic mode (`white_mode`=0), the feedback equals the tap A bit alone. With the defaults, starting from the reset state, `noise_out` first reads 1 after exactly 16 steps, and again every 15 steps after that.
- R7: With XNOR polarity (`XNOR_FEEDBACK`=1), white-mode feedback is tap A XOR (NOT tap B). Periodic mode is unchanged.
- R8: `white_mode` is sampled in the cycle of each step. A change made between steps affects only the steps that follow it.
- R9: `lfsr_clear` reloads the register to its reset value. It has priority over a step in the same cycle, which is then discarded. The countdown keeps running as if there were no clear.
- R10: `noise_out` is the register's lowest bit. It updates in the same clock edge as the step or clear, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Divided clock strobe, one cycle wide |
| period | input | PER_W (11) | Effective noise period in ticks |
| white_mode | input | 1 | 1 = white noise, 0 = periodic ring |
| lfsr_clear | input | 1 | Reload the shift register to its start value |
| noise_out | output | 1 | 1-bit noise level |

## Verification
A clear pulse and a countdown expiry can land in the same cycle. The bench provokes this by raising `lfsr_clear` on exactly the tick where the countdown reaches 1. It judges the outcome from the output pattern that follows: in periodic mode, `noise_out` must first read 1 only after a full 16 further steps from the cleared state. The countdown must also keep its spacing unchanged.

A mode change placed on the step tick itself, and another placed between steps, are both compared against a cycle model that is built from the requirements.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;

    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_pol_e;

    typedef struct packed {
        logic clear;
        logic step;
        logic white;
    } shift_ctrl_t;

    // Feedback value for one step; tap B is gated off outside white mode.
    function automatic logic feedback_bit(input logic tap_a, input logic tap_b,
                                          input logic white, input fb_pol_e pol);
        logic b_term;
        b_term = (pol == FB_XNOR) ? ~tap_b : tap_b;
        return tap_a ^ (b_term & white);
    endfunction

endpackage

// File: rtl/noise_period_counter.sv
module noise_period_counter #(
    parameter int PER_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt_q;

    assign step = tick && (cnt_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick) begin
            if (cnt_q <= ONE)
                cnt_q <= period;
            else
                cnt_q <= cnt_q - ONE;
        end
    end

    AST_RELOAD_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt_q == $past(period)); // R2

    AST_TICKLESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q)); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && !step) |=> cnt_q == $past(cnt_q) - ONE); // R2

endmodule

// File: rtl/noise_shift_core.sv
module noise_shift_core
    import noise_gen_pkg::*;
#(
    parameter int                LFSR_W     = 17,
    parameter logic [LFSR_W-1:0] TAP_A_MASK = LFSR_W'(4),
    parameter logic [LFSR_W-1:0] TAP_B_MASK = LFSR_W'(8),
    parameter fb_pol_e           POL        = FB_XOR
) (
    input  logic        clk,
    input  logic        rst,
    input  shift_ctrl_t ctrl,
    output logic        lsb_o
);
    localparam logic [LFSR_W-1:0] FB_MASK = {1'b1, {(LFSR_W-1){1'b0}}};

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_next;
    logic              tap_a, tap_b, fb;

    always_comb begin
        tap_a     = |(lfsr_q & TAP_A_MASK);
        tap_b     = |(lfsr_q & TAP_B_MASK);
        fb        = feedback_bit(tap_a, tap_b, ctrl.white, POL);
        lfsr_next = lfsr_q >> 1;
        if (fb)
            lfsr_next = lfsr_next | FB_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear)
            lfsr_q <= FB_MASK;
        else if (ctrl.step)
            lfsr_q <= lfsr_next;
    end

    assign lsb_o = lfsr_q[0];

    AST_CLEAR_LOADS_SEED: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> lfsr_q == FB_MASK); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.step) |=> $stable(lfsr_q)); // R10

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.step && !ctrl.clear) |=> lfsr_q[LFSR_W-2:0] == $past(lfsr_q[LFSR_W-1:1])); // R4

    AST_RING_RECIRC: assert property (@(posedge clk) disable iff (rst)
        (ctrl.step && !ctrl.clear && !ctrl.white)
            |=> lfsr_q[LFSR_W-1] == $past(tap_a)); // R6

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_gen_pkg::*;
#(
    parameter int                LFSR_W        = 17,
    parameter logic [LFSR_W-1:0] TAP_A_MASK    = LFSR_W'(4),
    parameter logic [LFSR_W-1:0] TAP_B_MASK    = LFSR_W'(8),
    parameter bit                XNOR_FEEDBACK = 1'b0,
    parameter int                PER_W         = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic             white_mode,
    input  logic             lfsr_clear,
    output logic             noise_out
);
    localparam fb_pol_e POL = XNOR_FEEDBACK ? FB_XNOR : FB_XOR;

    logic        step;
    shift_ctrl_t ctrl;

    noise_period_counter #(.PER_W(PER_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .period (period),
        .step   (step)
    );

    assign ctrl = '{clear: lfsr_clear, step: step, white: white_mode};

    noise_shift_core #(
        .LFSR_W     (LFSR_W),
        .TAP_A_MASK (TAP_A_MASK),
        .TAP_B_MASK (TAP_B_MASK),
        .POL        (POL)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .lsb_o (noise_out)
    );

    AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !lfsr_clear) |=> $stable(noise_out)); // R2

endmodule

// File: tb/noise_lfsr_gen_tb.sv
`timescale 1ns/1ps
module noise_lfsr_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [10:0] period = '0;
    logic        white_mode = 1'b0;
    logic        lfsr_clear = 1'b0;
    logic        out_x, out_n;

    int total = 0;
    int bad = 0;

    logic [16:0] m_x, m_n;
    int          m_cnt;

    always #2.5 clk = ~clk;

    noise_lfsr_gen u_dut (
        .clk(clk), .rst(rst), .tick(tick), .period(period),
        .white_mode(white_mode), .lfsr_clear(lfsr_clear), .noise_out(out_x)
    );

    noise_lfsr_gen #(.XNOR_FEEDBACK(1'b1)) u_dut_xn (
        .clk(clk), .rst(rst), .tick(tick), .period(period),
        .white_mode(white_mode), .lfsr_clear(lfsr_clear), .noise_out(out_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [16:0] model_step(input logic [16:0] s, input logic wh,
                                               input logic xn);
        logic b, fb;
        b  = xn ? ~s[3] : s[3];
        fb = s[2] ^ (b & wh);
        return {fb, s[16:1]};
    endfunction

    // One cycle: drive, clock, update model, compare after the edge.
    task automatic cyc(input logic t, input logic wh, input logic clr,
                       input int per, input string req);
        logic stp;
        tick = t; white_mode = wh; lfsr_clear = clr; period = 11'(per);
        @(posedge clk);
        stp = t && (m_cnt <= 1);
        if (t) m_cnt = (m_cnt <= 1) ? per : m_cnt - 1;
        if (clr) begin
            m_x = 17'h10000; m_n = 17'h10000;
        end else if (stp) begin
            m_x = model_step(m_x, wh, 1'b0);
            m_n = model_step(m_n, wh, 1'b1);
        end
        @(negedge clk);
        check(req, out_x, m_x[0]);
        check(req, out_n, m_n[0]);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0; lfsr_clear = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_x = 17'h10000; m_n = 17'h10000; m_cnt = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset out", out_x, 1'b0);
        check("R1 reset out xnor", out_n, 1'b0);
    endtask

    task automatic t_ring();
        int ones = 0;
        do_reset();
        for (int i = 1; i <= 31; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1, "R6 ring");
            if (i == 15) check("R6 before first one", out_x, 1'b0);
            if (i == 16) check("R6 first one at 16", out_x, 1'b1);
            if (i == 30) check("R6 gap", out_x, 1'b0);
            if (i == 31) check("R6 repeat at 31", out_x, 1'b1);
            if (out_x) ones++;
        end
        check("R6 ones count", logic'(ones == 2), 1'b1);
    endtask

    task automatic t_period_zero();
        do_reset();
        for (int i = 1; i <= 16; i++) cyc(1'b1, 1'b0, 1'b0, 0, "R3 period zero");
        check("R3 period 0 steps every tick", out_x, 1'b1);
    endtask

    task automatic t_spacing();
        do_reset();
        for (int i = 1; i <= 61; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4, "R2 spacing");
            cyc(1'b0, 1'b0, 1'b0, 4, "R2 idle hold");
            if (i == 60) check("R2 tick 60 still 0", out_x, 1'b0);
        end
        check("R2 first one at tick 61", out_x, 1'b1);
    endtask

    task automatic t_white();
        do_reset();
        for (int i = 0; i < 120; i++) cyc(1'b1, 1'b1, 1'b0, 1, "R5 R7 white");
        for (int i = 0; i < 60; i++) cyc(1'b1, 1'b1, 1'b0, 3, "R4 R5 white period 3");
    endtask

    task automatic t_mode_switch();
        do_reset();
        for (int i = 0; i < 40; i++) cyc(1'b1, i[2], 1'b0, 2, "R8 mode on ticks");
        for (int i = 0; i < 40; i++)
            cyc(i[0], i[3], 1'b0, 3, "R8 mode between steps");
    endtask

    task automatic t_clear();
        do_reset();
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0, 2, "R9 warmup");
        // counter now expires on the next tick (20 ticks, period 2, first step at tick 1)
        cyc(1'b1, 1'b0, 1'b1, 2, "R9 clear on step");
        check("R9 clear out", out_x, 1'b0);
        for (int i = 1; i <= 32; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 2, "R9 after clear");
            if (i == 31) check("R9 no one before 16 steps", out_x, 1'b0);
        end
        check("R9 first one after 16 steps", out_x, 1'b1);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, 2, "R10 hold no tick");
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ring();
        t_period_zero();
        t_spacing();
        t_white();
        t_mode_switch();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule